// File: doc/BRIEF.md
# Right Shift Register with Arithmetic Mode

This block is a small register that either captures a parallel word or shifts its contents one place toward the least significant bit on every rising clock edge. A mode select input picks how the vacated top bit is filled. In serial mode it takes an external serial bit. In arithmetic mode it keeps its own old value, so the sign bit is copied down and a signed value is halved.

An active-low clear empties the register at once, without waiting for a clock edge. There is no hold state: whenever load is low, every rising edge performs a shift. The block is meant as a building block inside serial converters and simple signed-arithmetic datapaths.

Top module: `shreg_arith`

## Requirements
- R1: While `clr_n` is low, `q` is all zeros, and it goes to zero as soon as `clr_n` falls, without waiting for a clock edge.
- R2: With `clr_n` high, `q` changes only at a rising edge of `clk`; input changes between edges do not reach `q`.
- R3: At a rising edge with `clr_n` high and `load` = 1, `q` takes the value of `par_in`.
- R4: At a rising edge with `clr_n` high, `load` = 0 and `arith` = 0, `q` becomes `{ser_in, q[3:1]}`. The serial bit enters bit 3.
- R5: At a rising edge with `clr_n` high, `load` = 0 and `arith` = 1, `q` becomes `{q[3], q[3:1]}`. The sign bit is replicated.
- R6: Clear overrides load: with `clr_n` low, `load` = 1 and an edge, `q` stays zero.
- R7: In arithmetic mode (`arith` = 1), the value of `ser_in` has no effect on `q`.
- R8: There is no hold state. Each rising edge with `load` = 0 and `clr_n` high shifts the register.
- R9: The scripted sequence gives the values computed from R3 to R5 at each step. The sequence is: load 0011, three serial shifts with 1, two serial shifts with 0 (ending in 0011), clear (0000), load 1100, then two arithmetic shifts (ending in 1111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Parallel load enable, active high |
| par_in | input | 4 | Parallel data word |
| arith | input | 1 | Shift mode: 0 takes the serial bit, 1 copies the sign bit |
| ser_in | input | 1 | Serial bit that enters the top bit in serial mode |
| q | output | 4 | Register contents |

## Verification
On every clock edge, the assertions check the next-state relations for load (R3), serial shift (R4) and arithmetic shift (R5, which also covers R7). They also check that `q` is zero whenever clear is sampled low (R1, R6). Some behaviours can only be shown by the bench's scenarios. These are the clear taking effect asynchronously in mid-cycle, `q` staying stable while inputs change between edges (R2), `ser_in` toggling with no visible effect in arithmetic mode, and the full scripted sequence (R9).

// File: rtl/shreg_pkg.sv
// Package: shared types for the right shift register.
// Assumes: one select bit picks the fill source of the top bit.
package shreg_pkg;
    typedef enum logic {
        FILL_SERIAL = 1'b0,
        FILL_SIGN   = 1'b1
    } fill_mode_e;
endpackage

// File: rtl/shreg_fill_sel.sv
// Module: picks the bit that enters the top position during a shift.
// Assumes: the mode is already decoded to the package enum.
module shreg_fill_sel
    import shreg_pkg::*;
(
    input  fill_mode_e mode,
    input  logic       ser_bit,
    input  logic       top_bit,
    output logic       fill_bit
);
    // Purpose: serial bit in serial mode, current sign bit in arithmetic mode.
    always_comb begin
        unique case (mode)
            FILL_SIGN:   fill_bit = top_bit;
            default:     fill_bit = ser_bit;
        endcase
    end
endmodule

// File: rtl/shreg_cell.sv
// Module: one storage bit of the register, a D flip-flop with a load/shift mux.
// Assumes: clear is asynchronous and active low; load outranks shift.
module shreg_cell (
    input  logic clk,
    input  logic clr_n,
    input  logic load,
    input  logic par_bit,
    input  logic shift_bit,
    output logic q_bit
);
    logic d_bit;

    // Purpose: choose the parallel bit on load, else the neighbour bit.
    always_comb begin
        d_bit = load ? par_bit : shift_bit;
    end

    // Purpose: store the chosen bit; clear wins at any time.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_bit <= 1'b0;
        else        q_bit <= d_bit;
    end
endmodule

// File: rtl/shreg_arith.sv
// Module: right shift register with a parallel load and two shift modes.
// Assumes: no hold state; with load low every edge shifts toward bit 0.
module shreg_arith
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load,
    input  logic [WIDTH-1:0] par_in,
    input  logic             arith,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    fill_mode_e       mode;
    logic             fill_bit;
    logic [WIDTH-1:0] shift_src;

    // Purpose: decode the select pin into the fill mode.
    always_comb begin
        mode = arith ? FILL_SIGN : FILL_SERIAL;
    end

    shreg_fill_sel u_fill (
        .mode     (mode),
        .ser_bit  (ser_in),
        .top_bit  (q[TOP]),
        .fill_bit (fill_bit)
    );

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            if (i == TOP) begin : g_top
                assign shift_src[i] = fill_bit;
            end else begin : g_low
                assign shift_src[i] = q[i+1];
            end
            shreg_cell u_cell (
                .clk       (clk),
                .clr_n     (clr_n),
                .load      (load),
                .par_bit   (par_in[i]),
                .shift_bit (shift_src[i]),
                .q_bit     (q[i])
            );
        end
    endgenerate
endmodule

// File: rtl/shreg_arith_chk.sv
// Module: assertion checker for shreg_arith, attached by bind.
// Assumes: clk runs while clear is applied.
module shreg_arith_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load,
    input logic [WIDTH-1:0] par_in,
    input logic             arith,
    input logic             ser_in,
    input logic [WIDTH-1:0] q
);
    // Purpose: R1 and R6, output is zero whenever clear is sampled low.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            a_r1_clear_zero: assert (q == '0)
                else $error("R1/R6 q not zero during clear");
        end
    end

    a_r3_load_takes_word: assert property (@(posedge clk) disable iff (!clr_n)
        load |=> q == $past(par_in))
        else $error("R3 load mismatch");

    a_r4_serial_shift: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && !arith) |=> q == {$past(ser_in), $past(q[WIDTH-1:1])})
        else $error("R4 serial shift mismatch");

    a_r5_sign_shift: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && arith) |=> q == {$past(q[WIDTH-1]), $past(q[WIDTH-1:1])})
        else $error("R5/R7 arithmetic shift mismatch");
endmodule

bind shreg_arith shreg_arith_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .load   (load),
    .par_in (par_in),
    .arith  (arith),
    .ser_in (ser_in),
    .q      (q)
);

// File: tb/shreg_arith_test.sv
`timescale 1ns/1ps
module shreg_arith_test;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load = 1'b0;
    logic [3:0] par_in = '0;
    logic       arith = 1'b0;
    logic       ser_in = 1'b0;
    logic [3:0] q;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [3:0] model = '0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    shreg_arith #(.WIDTH(4)) uut (
        .clk(clk), .clr_n(clr_n), .load(load), .par_in(par_in),
        .arith(arith), .ser_in(ser_in), .q(q)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: q=%b expected %b", tag, act, exp);
        end
    endtask

    // Driver: set inputs after a falling edge, push the value expected after the next rising edge.
    task automatic step(input logic ld, input logic [3:0] d, input logic sel,
                        input logic si, input string tag);
        @(negedge clk);
        load = ld; par_in = d; arith = sel; ser_in = si;
        if (ld)       model = d;
        else if (sel) model = {model[3], model[3:1]};
        else          model = {si, model[3:1]};
        exp_q.push_back(model);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    // Monitor: shortly after each rising edge, compare against the scoreboard.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) check(q, exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #100000;
        tests++; fails++;
        $display("FAIL watchdog: q=%b expected completion", q);
        finish_run();
    end

    initial begin
        // R1 reset state, with load held high during clear (R6)
        load = 1'b1; par_in = 4'b1010;
        repeat (3) @(posedge clk);
        #1 check(q, 4'b0000, "R6 clear beats load");
        load = 1'b0;
        @(negedge clk); clr_n = 1'b1; model = '0;

        // R9 scripted sequence
        step(1'b1, 4'b0011, 1'b0, 1'b0, "R9/R3 load 0011");
        for (int k = 0; k < 3; k++) step(1'b0, 4'b0000, 1'b0, 1'b1, "R9/R4 serial 1");
        for (int k = 0; k < 2; k++) step(1'b0, 4'b0000, 1'b0, 1'b0, "R9/R4 serial 0");
        #2 check(q, 4'b0011, "R9 after serial shifts");
        @(negedge clk); clr_n = 1'b0; #0.5;
        check(q, 4'b0000, "R1 asynchronous clear");
        @(negedge clk); clr_n = 1'b1; model = '0;
        step(1'b1, 4'b1100, 1'b0, 1'b0, "R9/R3 load 1100");
        for (int k = 0; k < 2; k++) step(1'b0, 4'b0000, 1'b1, 1'b0, "R9/R5 arith");
        #2 check(q, 4'b1111, "R9 final 1111");

        // R5 and R7: positive value in arithmetic mode, ser_in toggled
        step(1'b1, 4'b0110, 1'b0, 1'b0, "R3 load 0110");
        step(1'b0, 4'b1111, 1'b1, 1'b1, "R7 arith ignores ser_in=1");
        step(1'b0, 4'b0000, 1'b1, 1'b1, "R5 arith positive");
        step(1'b1, 4'b1001, 1'b1, 1'b0, "R3 load with arith set");
        step(1'b0, 4'b0000, 1'b1, 1'b0, "R7 arith ignores ser_in=0");
        step(1'b0, 4'b0000, 1'b1, 1'b1, "R7 arith ser_in=1");

        // R8: every edge with load low shifts
        step(1'b1, 4'b1000, 1'b0, 1'b0, "R3 load 1000");
        for (int k = 0; k < 4; k++) step(1'b0, 4'b0000, 1'b0, 1'b0, "R8 shift each edge");
        step(1'b0, 4'b0000, 1'b0, 1'b1, "R4 serial enters top");

        // R2: mid-cycle input change does not reach q
        @(negedge clk);
        load = 1'b1; par_in = 4'b0101;
        #1 check(q, model, "R2 no change between edges");
        @(posedge clk); #1 check(q, 4'b0101, "R2/R3 load at edge");
        model = 4'b0101;
        load = 1'b0;

        repeat (3) @(posedge clk);
        #2 finish_run();
    end
endmodule